// File: doc/BRIEF.md
# Proximity-Qualified Pump Controller

This block switches a water pump relay from one hand-proximity sensor. The sensor line arrives with no relation to the clock and may bounce, so the block first passes it through a flop synchronizer. A stable-level filter follows, and only then does the signal reach a small sequencer. The pump starts only after presence has lasted through a qualification interval. It runs while the hand stays. When the hand leaves, the pump keeps running for a hold interval before it stops.

All intervals are set in milliseconds and turned into cycle counts from a clock-frequency parameter. A simulation can therefore use a slow clock and short windows. A polarity parameter lets the block accept sensor modules that pull their output low on detection. An optional on-time limit stops the pump when presence lasts too long. After that stop, the hand must leave before the pump can qualify again. There is no data stream, so every pin is a plain level signal with no handshake.

Top module: `presence_pump_ctrl`

## Requirements
- R1: The filtered presence level changes only after the synchronized sensor level has held its new value for FILT_CYC consecutive cycles. A pulse or dropout shorter than that has no effect on `pump_en`, and it does not advance a later qualification.
- R2: From the clock edge that first samples a sensor change to presence, `pump_en` rises on edge number FILT_CYC+ON_CYC+2, counting that edge as number 1. This holds when presence stays continuous and the pump starts from off.
- R3: When filtered presence ends before qualification completes, the qualification count returns to zero and the pump stays off. A later attempt again needs the full R2 delay.
- R4: While the pump is on and filtered presence continues, `pump_en` stays high. The only exception is the R9 limit.
- R5: From the edge that first samples a sensor change to absence, `pump_en` falls on edge number FILT_CYC+HOLD_CYC+2 when no presence returns.
- R6: When presence returns during the hold, the pump stays on with no new qualification. The next end of presence starts a full hold of HOLD_CYC cycles.
- R7: With ACTIVE_LOW=1, a low sensor level means presence, and the block behaves exactly as the active-high build does when fed the inverted level.
- R8: A synchronous reset forces `pump_en` low on the next edge and clears the synchronizer, filter, counters and state. After reset, the pump needs the full R2 delay.
- R9: With MAX_ON_MS nonzero, the pump turns off MAX_CYC cycles after it turned on, provided presence stays continuous. It then stays off while presence lasts. It may qualify again, with the full R2 delay, only after filtered presence has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| sensor_in | input | 1 | Raw proximity sensor level, asynchronous; polarity set by ACTIVE_LOW |
| pump_en | output | 1 | Registered pump relay enable, high = pump running |

## Verification
The bench builds the block with CLK_HZ=1000, so one millisecond is one clock cycle. It uses a 4 ms filter, a 20 ms on-delay, a 40 ms hold and a 150 ms on-time limit. These values put every window within a few hundred cycles. The exact edge on which the pump starts, stops or locks out can then be checked alongside glitches, partial qualifications and returns during the hold. A second instance is built with ACTIVE_LOW=1 and fed the inverted sensor line, and every expected value is compared against both instances.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [1:0] {
    PC_OFF  = 2'd0,
    PC_ON   = 2'd1,
    PC_HOLD = 2'd2,
    PC_LOCK = 2'd3
  } pc_state_e;

  // CLK_HZ is expected to be a whole multiple of 1000.
  function automatic int unsigned pc_ms_to_cyc(input int unsigned hz, input int unsigned ms);
    return (hz / 1000) * ms;
  endfunction

  function automatic int unsigned pc_at_least(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pc_glitch_filter.sv
module pc_glitch_filter #(
  parameter int unsigned STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic level_q;

  generate
    if (STABLE_CYC <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= d;
      end
    end else begin : g_count
      localparam int unsigned CW = (STABLE_CYC > 2) ? $clog2(STABLE_CYC) : 1;
      logic [CW-1:0] run_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          level_q <= 1'b0;
          run_q   <= '0;
        end else if (d == level_q) begin
          run_q <= '0;
        end else if (run_q == CW'(STABLE_CYC - 1)) begin
          level_q <= d;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  endgenerate

  assign q = level_q;
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_pkg::*;
#(
  parameter int unsigned ON_CYC   = 2,
  parameter int unsigned HOLD_CYC = 2,
  parameter int unsigned MAX_CYC  = 0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pres,
  output logic      pump_en,
  output pc_state_e state_o
);
  localparam int unsigned TMAX = (ON_CYC > HOLD_CYC) ? ON_CYC : HOLD_CYC;
  localparam int unsigned TW   = (TMAX > 2) ? $clog2(TMAX) : 1;

  pc_state_e   state, nxt;
  logic [TW-1:0] tcnt, tcnt_nxt;
  logic        max_hit;
  logic        pump_q;

  generate
    if (MAX_CYC > 0) begin : g_limit
      localparam int unsigned MW = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
      logic [MW-1:0] mcnt;

      assign max_hit = (state == PC_ON) && pres && (mcnt == MW'(MAX_CYC - 1));

      always_ff @(posedge clk) begin
        if (rst || state != PC_ON) mcnt <= '0;
        else if (pres && !max_hit) mcnt <= mcnt + 1'b1;
      end
    end else begin : g_nolimit
      assign max_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    nxt      = state;
    tcnt_nxt = tcnt;
    unique case (state)
      PC_OFF: begin
        if (!pres) begin
          tcnt_nxt = '0;
        end else if (tcnt == TW'(ON_CYC - 1)) begin
          nxt      = PC_ON;
          tcnt_nxt = '0;
        end else begin
          tcnt_nxt = tcnt + 1'b1;
        end
      end
      PC_ON: begin
        tcnt_nxt = '0;
        if (!pres) begin
          nxt      = PC_HOLD;
          tcnt_nxt = TW'(1);
        end else if (max_hit) begin
          nxt = PC_LOCK;
        end
      end
      PC_HOLD: begin
        if (pres) begin
          nxt      = PC_ON;
          tcnt_nxt = '0;
        end else if (tcnt == TW'(HOLD_CYC - 1)) begin
          nxt      = PC_OFF;
          tcnt_nxt = '0;
        end else begin
          tcnt_nxt = tcnt + 1'b1;
        end
      end
      PC_LOCK: begin
        tcnt_nxt = '0;
        if (!pres) nxt = PC_OFF;
      end
      default: begin
        nxt      = PC_OFF;
        tcnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PC_OFF;
      tcnt   <= '0;
      pump_q <= 1'b0;
    end else begin
      state  <= nxt;
      tcnt   <= tcnt_nxt;
      pump_q <= (nxt == PC_ON) || (nxt == PC_HOLD);
    end
  end

  assign pump_en = pump_q;
  assign state_o = state;
endmodule

// File: rtl/presence_pump_ctrl.sv
module presence_pump_ctrl
  import pc_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned FILTER_MS   = 2,
  parameter int unsigned ON_DELAY_MS = 1000,
  parameter int unsigned HOLD_MS     = 2000,
  parameter int unsigned MAX_ON_MS   = 0,
  parameter bit          ACTIVE_LOW  = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sensor_in,
  output logic pump_en
);
  localparam int unsigned FILT_CYC = pc_at_least(pc_ms_to_cyc(CLK_HZ, FILTER_MS), 1);
  localparam int unsigned ON_CYC   = pc_at_least(pc_ms_to_cyc(CLK_HZ, ON_DELAY_MS), 2);
  localparam int unsigned HOLD_CYC = pc_at_least(pc_ms_to_cyc(CLK_HZ, HOLD_MS), 2);
  localparam int unsigned MAX_CYC  = (MAX_ON_MS == 0) ? 0 :
                                     pc_at_least(pc_ms_to_cyc(CLK_HZ, MAX_ON_MS), 2);

  logic      sensor_s;
  logic      pres_sync;
  logic      pres_filt;
  pc_state_e seq_state;

  // Reset to the inactive sensor level so neither polarity reads as presence.
  pc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(ACTIVE_LOW)) u_sync (
    .clk(clk), .rst(rst), .d(sensor_in), .q(sensor_s)
  );

  assign pres_sync = sensor_s ^ ACTIVE_LOW;

  pc_glitch_filter #(.STABLE_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst(rst), .d(pres_sync), .q(pres_filt)
  );

  pc_seq #(.ON_CYC(ON_CYC), .HOLD_CYC(HOLD_CYC), .MAX_CYC(MAX_CYC)) u_seq (
    .clk(clk), .rst(rst), .pres(pres_filt), .pump_en(pump_en), .state_o(seq_state)
  );
endmodule

// File: rtl/pc_checker.sv
module pc_checker
  import pc_pkg::*;
#(
  parameter int unsigned FILT_CYC = 1,
  parameter int unsigned ON_CYC   = 2,
  parameter int unsigned HOLD_CYC = 2
) (
  input logic      clk,
  input logic      rst,
  input logic      pres_sync,
  input logic      pres,
  input logic      pump_en,
  input pc_state_e state
);
  localparam int unsigned CAP = 32'h00FF_FFFF;

  int unsigned sync_hi, sync_lo, pres_hi, pres_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_hi <= 0; sync_lo <= 0; pres_hi <= 0; pres_lo <= 0;
    end else begin
      sync_hi <= pres_sync  ? ((sync_hi < CAP) ? sync_hi + 1 : CAP) : 0;
      sync_lo <= !pres_sync ? ((sync_lo < CAP) ? sync_lo + 1 : CAP) : 0;
      pres_hi <= pres       ? ((pres_hi < CAP) ? pres_hi + 1 : CAP) : 0;
      pres_lo <= !pres      ? ((pres_lo < CAP) ? pres_lo + 1 : CAP) : 0;
    end
  end

  p_filter_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pres) |-> (sync_hi >= FILT_CYC));
  p_filter_fall_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(pres) |-> (sync_lo >= FILT_CYC));
  p_on_qualified_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_en) |-> (pres_hi >= ON_CYC));
  p_stay_on_r4: assert property (@(posedge clk) disable iff (rst)
    (pump_en && pres) |=> (pump_en || state == PC_LOCK));
  p_hold_full_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(pump_en) |-> (pres_lo >= HOLD_CYC || state == PC_LOCK));
  p_reset_off_r8: assert property (@(posedge clk)
    rst |=> (!pump_en && state == PC_OFF));
  p_lock_exit_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == PC_LOCK && state != PC_LOCK) |-> !$past(pres));
endmodule

bind presence_pump_ctrl pc_checker #(
  .FILT_CYC(FILT_CYC), .ON_CYC(ON_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst(rst), .pres_sync(pres_sync), .pres(pres_filt),
  .pump_en(pump_en), .state(seq_state)
);

// File: tb/sim_presence_pump_ctrl.sv
module sim_presence_pump_ctrl;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned CLK_HZ = 1000;
  localparam int unsigned FILT   = 4 * CLK_HZ / 1000;
  localparam int unsigned ON     = 20 * CLK_HZ / 1000;
  localparam int unsigned HOLD   = 40 * CLK_HZ / 1000;
  localparam int unsigned MAXC   = 150 * CLK_HZ / 1000;
  localparam int unsigned T_ON   = FILT + ON + 2;
  localparam int unsigned T_OFF  = FILT + HOLD + 2;

  typedef struct {
    int unsigned at;
    bit          val;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic raw_n;
  logic pump_hi, pump_lo;
  int unsigned cyc = 0;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;
  exp_t q[$];

  assign raw_n = ~raw;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  presence_pump_ctrl #(.CLK_HZ(CLK_HZ), .FILTER_MS(4), .ON_DELAY_MS(20), .HOLD_MS(40),
    .MAX_ON_MS(150), .ACTIVE_LOW(1'b0)) u0 (
    .clk(clk), .rst(rst), .sensor_in(raw), .pump_en(pump_hi));

  presence_pump_ctrl #(.CLK_HZ(CLK_HZ), .FILTER_MS(4), .ON_DELAY_MS(20), .HOLD_MS(40),
    .MAX_ON_MS(150), .ACTIVE_LOW(1'b1)) u1 (
    .clk(clk), .rst(rst), .sensor_in(raw_n), .pump_en(pump_lo));

  task automatic push_exp(input int unsigned at, input bit v, input string tag);
    exp_t e;
    e.at = at; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input bit expv, input string tag, input int unsigned at);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cycle %0d: pump_en=%b expected %b", tag, at, act, expv);
    end
  endtask

  // Monitor: pops each expectation when its cycle comes and compares both builds.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t it;
      it = q.pop_front();
      check(pump_hi, it.val, it.tag, cyc);
      check(pump_lo, it.val, "R7 active-low", cyc);
    end
  end

  initial begin
    int unsigned c;
    int unsigned c2;
    step(3);
    // R8: reset state
    rst = 1'b0;
    push_exp(cyc + 1, 1'b0, "R8 after reset");
    push_exp(cyc + 5, 1'b0, "R8 idle");
    step(6);

    // R1: a 3-cycle pulse must not advance qualification; R2: exact start edge
    raw = 1'b1; step(3);
    raw = 1'b0; step(1);
    raw = 1'b1; c = cyc;
    push_exp(c + T_ON - 1, 1'b0, "R1 glitch ignored");
    push_exp(c + T_ON,     1'b1, "R2 qualified start");
    drain();

    // R4: held presence keeps pump on
    step(60);
    push_exp(cyc + 1, 1'b1, "R4 stays on");
    drain();

    // R1: short dropout while on is filtered
    raw = 1'b0; step(FILT - 1);
    raw = 1'b1;
    push_exp(cyc + 20, 1'b1, "R1 dropout ignored");
    drain();

    // R5: hold after presence ends
    raw = 1'b0; c = cyc;
    push_exp(c + T_OFF - 1, 1'b1, "R5 still holding");
    push_exp(c + T_OFF,     1'b0, "R5 off after hold");
    drain();

    // R3: partial qualification is discarded
    step(10);
    raw = 1'b1; step(15);
    raw = 1'b0; step(10);
    push_exp(cyc + 1, 1'b0, "R3 partial stays off");
    raw = 1'b1; c = cyc;
    push_exp(c + T_ON - 1, 1'b0, "R3 full delay again");
    push_exp(c + T_ON,     1'b1, "R3 start");
    drain();

    // R6: presence returns during hold, then a full hold restarts
    step(5);
    raw = 1'b0; c = cyc;
    step(20);
    raw = 1'b1;
    push_exp(c + T_OFF, 1'b1, "R6 return keeps on");
    step(40);
    raw = 1'b0; c2 = cyc;
    push_exp(c2 + T_OFF - 1, 1'b1, "R6 hold restarted");
    push_exp(c2 + T_OFF,     1'b0, "R6 off");
    drain();

    // R9: on-time limit, lockout, requalify after absence
    step(5);
    raw = 1'b1; c = cyc;
    push_exp(c + T_ON, 1'b1, "R2 start before limit");
    push_exp(c + T_ON + MAXC - 1, 1'b1, "R9 before limit");
    push_exp(c + T_ON + MAXC,     1'b0, "R9 limit off");
    drain();
    step(30);
    push_exp(cyc + 1, 1'b0, "R9 locked while present");
    step(2);
    raw = 1'b0; step(10);
    raw = 1'b1; c = cyc;
    push_exp(c + T_ON - 1, 1'b0, "R9 requalify delay");
    push_exp(c + T_ON,     1'b1, "R9 requalified");
    drain();
    raw = 1'b0;
    step(T_OFF + 10);

    // R8: reset while running clears everything
    raw = 1'b1; c = cyc;
    push_exp(c + T_ON, 1'b1, "R8 running before reset");
    step(35);
    rst = 1'b1;
    push_exp(cyc + 1, 1'b0, "R8 reset forces off");
    step(2);
    rst = 1'b0; c = cyc;
    push_exp(c + T_ON - 1, 1'b0, "R8 full delay after reset");
    push_exp(c + T_ON,     1'b1, "R8 start after reset");
    drain();
    raw = 1'b0;
    step(T_OFF + 5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule